// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This bridge sits between a processor-side request port and a downstream memory port. It lets software treat each single bit of two 1 MB backing regions as a full 32-bit word. Each backing region has a 32 MB alias window, and every word in that window stands for one bit of the backing region. Any access to an address outside both alias windows goes straight through to the downstream port.

An alias read fetches the backing word and returns only the addressed bit, in bit 0. An alias write turns into a locked read-modify-write. The bridge reads the backing word, replaces the addressed bit with bit 0 of the write data, and writes the word back. No other downstream transaction can come between the read and the write-back. The bridge works on one upstream request at a time.

Top module: `bitalias_bridge`

## Requirements
- R1: A read whose address lies outside both alias windows is sent downstream once, with the same address, unlocked. The returned data reaches the upstream port unchanged. Direct accesses to the backing regions are also passed through unchanged.
- R2: A write outside both alias windows is sent downstream once, with the same address and write data, unlocked. Its upstream response carries zero data.
- R3: An alias address A, in a window with alias base W and backing base B, maps to one backing word and one bit position:
  - byte offset k = (A − W) / 32;
  - backing word address = B + (k with its two low bits cleared);
  - bit position = (k mod 4) × 8 + A[4:2].
- R4: An alias read returns the addressed bit in bit 0 of the response, with bits 31:1 zero.
- R5: An alias write sets the addressed bit to bit 0 of the write data, ignoring all other write-data bits. Every other bit of the backing word keeps its value.
- R6: An alias write produces exactly two downstream transfers in order: a read of the backing word, then a write of the same word. The lock output is high from the read request until the write is accepted. It is low for all other accesses.
- R7: The upstream ready is low from the cycle after a request is accepted until its response is returned. Each request produces exactly one downstream transfer, except an alias write, which produces two.
- R8: Every accepted request produces exactly one single-cycle upstream response pulse. The pulse comes one cycle after the final downstream response.
- R9: During and right after reset, upstream ready is high, and downstream valid, lock and the upstream response valid are low.
- R10: The two regions and their boundaries:
  - SRAM region: backing base 0x20000000, alias base 0x22000000.
  - Peripheral region: backing base 0x40000000, alias base 0x42000000.
  - The first alias word of a window maps to bit 0 of the first backing word.
  - The last alias word (base + 0x1FFFFFC) maps to bit 31 of backing word base + 0xFFFFC.
  - Addresses just outside a window are passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_addr | input | 32 | Upstream byte address |
| up_we | input | 1 | Upstream write enable |
| up_wdata | input | 32 | Upstream write data |
| up_rvalid | output | 1 | Upstream response pulse |
| up_rdata | output | 32 | Upstream response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_addr | output | 32 | Downstream word address |
| dn_we | output | 1 | Downstream write enable |
| dn_wdata | output | 32 | Downstream write data |
| dn_lock | output | 1 | Downstream lock for the read-modify-write sequence |
| dn_rvalid | input | 1 | Downstream response pulse |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions check on every cycle the rules that hold in any state:
- the lock stays high until the write-back is accepted;
- a stalled downstream request holds its address and direction;
- ready falls after each accepted request;
- responses are single pulses;
- a merge changes at most one bit.

Only the bench's scenarios can show that the right bit is chosen and the backing data stays correct. It replays each access against a behavioural memory and checks the address mapping at the first and last bit of each window. It also checks that upper write-data bits are ignored and that addresses just outside the windows pass through.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

    typedef enum logic [3:0] {
        S_IDLE    = 4'd0,
        S_PASS    = 4'd1,
        S_PASS_W  = 4'd2,
        S_ARD     = 4'd3,
        S_ARD_W   = 4'd4,
        S_LRD     = 4'd5,
        S_LRD_W   = 4'd6,
        S_LWR     = 4'd7,
        S_LWR_W   = 4'd8
    } bb_state_e;

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BAND_LOG2 = 20,
    parameter int NREG      = 2,
    parameter logic [NREG*ADDR_W-1:0] BACK_BASES  = '0,
    parameter logic [NREG*ADDR_W-1:0] ALIAS_BASES = '0
) (
    input  logic [ADDR_W-1:0]          addr_i,
    output logic                       alias_o,
    output logic [ADDR_W-1:0]          word_addr_o,
    output logic [$clog2(DATA_W)-1:0]  bit_idx_o
);
    localparam int WB_LOG2     = $clog2(DATA_W / 8);
    localparam int SPREAD_LOG2 = $clog2(DATA_W);
    localparam int ALIAS_LOG2  = BAND_LOG2 + SPREAD_LOG2;
    localparam int BITNUM_W    = SPREAD_LOG2 - WB_LOG2;

    logic [NREG-1:0]       hit;
    logic [ADDR_W-1:0]     waddr [NREG];
    logic [BAND_LOG2-1:0]  byte_off;
    logic [BITNUM_W-1:0]   bitnum;

    assign byte_off = addr_i[ALIAS_LOG2-1:SPREAD_LOG2];
    assign bitnum   = addr_i[SPREAD_LOG2-1:WB_LOG2];

    for (genvar g = 0; g < NREG; g++) begin : g_region
        localparam logic [ADDR_W-1:0] ABASE = ALIAS_BASES[g*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] BBASE = BACK_BASES[g*ADDR_W +: ADDR_W];
        assign hit[g]   = (addr_i[ADDR_W-1:ALIAS_LOG2] == ABASE[ADDR_W-1:ALIAS_LOG2]);
        assign waddr[g] = {BBASE[ADDR_W-1:BAND_LOG2],
                           byte_off[BAND_LOG2-1:WB_LOG2],
                           {WB_LOG2{1'b0}}};
    end

    always_comb begin
        alias_o     = |hit;
        word_addr_o = addr_i;
        for (int r = 0; r < NREG; r++) begin
            if (hit[r]) word_addr_o = waddr[r];
        end
        bit_idx_o = {byte_off[WB_LOG2-1:0], bitnum};
    end

endmodule

// File: rtl/bitalias_bitops.sv
module bitalias_bitops #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]          word_i,
    input  logic [$clog2(DATA_W)-1:0]  bidx_i,
    input  logic                       nbit_i,
    output logic [DATA_W-1:0]          bit_o,
    output logic [DATA_W-1:0]          merged_o
);
    always_comb begin
        bit_o            = '0;
        bit_o[0]         = word_i[bidx_i];
        merged_o         = word_i;
        merged_o[bidx_i] = nbit_i;
    end

    // R5: merging never disturbs more than the one target bit
    always_comb begin
        p_merge_one_bit_r5: assert ($countones(merged_o ^ word_i) <= 1)
            else $error("merge touched several bits");
    end

endmodule

// File: rtl/bitalias_ctrl.sv
module bitalias_ctrl
    import bitalias_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       up_valid,
    input  logic [ADDR_W-1:0]          up_addr,
    input  logic                       up_we,
    input  logic [DATA_W-1:0]          up_wdata,
    output logic                       up_ready,
    output logic                       up_rvalid,
    output logic [DATA_W-1:0]          up_rdata,
    input  logic                       dec_alias,
    input  logic [ADDR_W-1:0]          dec_word_addr,
    input  logic [$clog2(DATA_W)-1:0]  dec_bit_idx,
    input  logic [DATA_W-1:0]          bit_val,
    input  logic [DATA_W-1:0]          merged_in,
    output logic [$clog2(DATA_W)-1:0]  bidx_o,
    output logic                       nbit_o,
    output logic                       dn_valid,
    input  logic                       dn_ready,
    output logic [ADDR_W-1:0]          dn_addr,
    output logic                       dn_we,
    output logic [DATA_W-1:0]          dn_wdata,
    output logic                       dn_lock,
    input  logic                       dn_rvalid,
    input  logic [DATA_W-1:0]          dn_rdata
);
    localparam int BIDX_W = $clog2(DATA_W);

    typedef struct packed {
        bb_state_e          state;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic               we;
        logic [BIDX_W-1:0]  bidx;
        logic               nbit;
        logic               rvalid;
        logic [DATA_W-1:0]  rdata;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.rvalid = 1'b0;
        up_ready = (r_q.state == S_IDLE);
        dn_valid = 1'b0;
        dn_we    = 1'b0;
        dn_lock  = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (up_valid) begin
                    r_d.addr  = dec_alias ? dec_word_addr : up_addr;
                    r_d.wdata = up_wdata;
                    r_d.we    = up_we;
                    r_d.bidx  = dec_bit_idx;
                    r_d.nbit  = up_wdata[0];
                    if (!dec_alias)  r_d.state = S_PASS;
                    else if (up_we)  r_d.state = S_LRD;
                    else             r_d.state = S_ARD;
                end
            end
            S_PASS: begin
                dn_valid = 1'b1;
                dn_we    = r_q.we;
                if (dn_ready) r_d.state = S_PASS_W;
            end
            S_PASS_W: begin
                if (dn_rvalid) begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = r_q.we ? '0 : dn_rdata;
                    r_d.state  = S_IDLE;
                end
            end
            S_ARD: begin
                dn_valid = 1'b1;
                if (dn_ready) r_d.state = S_ARD_W;
            end
            S_ARD_W: begin
                if (dn_rvalid) begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = bit_val;
                    r_d.state  = S_IDLE;
                end
            end
            S_LRD: begin
                dn_valid = 1'b1;
                dn_lock  = 1'b1;
                if (dn_ready) r_d.state = S_LRD_W;
            end
            S_LRD_W: begin
                dn_lock = 1'b1;
                if (dn_rvalid) begin
                    r_d.wdata = merged_in;
                    r_d.state = S_LWR;
                end
            end
            S_LWR: begin
                dn_valid = 1'b1;
                dn_we    = 1'b1;
                dn_lock  = 1'b1;
                if (dn_ready) r_d.state = S_LWR_W;
            end
            S_LWR_W: begin
                if (dn_rvalid) begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = '0;
                    r_d.state  = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dn_addr   = r_q.addr;
    assign dn_wdata  = r_q.wdata;
    assign up_rvalid = r_q.rvalid;
    assign up_rdata  = r_q.rdata;
    assign bidx_o    = r_q.bidx;
    assign nbit_o    = r_q.nbit;

    // R6: once raised, the lock stays up until the write-back is taken
    p_lock_until_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_lock && !(dn_valid && dn_ready && dn_we)) |=> dn_lock);

    // R6: the write-back targets the word that was read under lock
    p_lock_same_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_lock && dn_valid && dn_ready && !dn_we) |=> (dn_lock && dn_addr == $past(dn_addr)));

    // R1: a stalled downstream request keeps its address and direction
    p_dn_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_we)));

    // R7: only one request in flight
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> !up_ready);

    // R8: the response is a single-cycle pulse
    p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |=> !up_rvalid);

    // R4: an alias read answers with bit 0 only
    p_alias_rd_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_ARD_W && dn_rvalid) |=> (up_rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BAND_LOG2  = 20,
    parameter logic [31:0] SRAM_BACK  = 32'h2000_0000,
    parameter logic [31:0] SRAM_ALIAS = 32'h2200_0000,
    parameter logic [31:0] PERI_BACK  = 32'h4000_0000,
    parameter logic [31:0] PERI_ALIAS = 32'h4200_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_valid,
    output logic               up_ready,
    input  logic [ADDR_W-1:0]  up_addr,
    input  logic               up_we,
    input  logic [DATA_W-1:0]  up_wdata,
    output logic               up_rvalid,
    output logic [DATA_W-1:0]  up_rdata,
    output logic               dn_valid,
    input  logic               dn_ready,
    output logic [ADDR_W-1:0]  dn_addr,
    output logic               dn_we,
    output logic [DATA_W-1:0]  dn_wdata,
    output logic               dn_lock,
    input  logic               dn_rvalid,
    input  logic [DATA_W-1:0]  dn_rdata
);
    localparam int NREG   = 2;
    localparam int BIDX_W = $clog2(DATA_W);
    localparam logic [NREG*ADDR_W-1:0] BACKS   = {PERI_BACK[ADDR_W-1:0],  SRAM_BACK[ADDR_W-1:0]};
    localparam logic [NREG*ADDR_W-1:0] ALIASES = {PERI_ALIAS[ADDR_W-1:0], SRAM_ALIAS[ADDR_W-1:0]};

    logic               dec_alias;
    logic [ADDR_W-1:0]  dec_word_addr;
    logic [BIDX_W-1:0]  dec_bit_idx;
    logic [BIDX_W-1:0]  bidx_q;
    logic               nbit_q;
    logic [DATA_W-1:0]  bit_val;
    logic [DATA_W-1:0]  merged;

    bitalias_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BAND_LOG2(BAND_LOG2), .NREG(NREG),
        .BACK_BASES(BACKS), .ALIAS_BASES(ALIASES)
    ) u_decode (
        .addr_i      (up_addr),
        .alias_o     (dec_alias),
        .word_addr_o (dec_word_addr),
        .bit_idx_o   (dec_bit_idx)
    );

    bitalias_bitops #(.DATA_W(DATA_W)) u_bitops (
        .word_i   (dn_rdata),
        .bidx_i   (bidx_q),
        .nbit_i   (nbit_q),
        .bit_o    (bit_val),
        .merged_o (merged)
    );

    bitalias_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_valid      (up_valid),
        .up_addr       (up_addr),
        .up_we         (up_we),
        .up_wdata      (up_wdata),
        .up_ready      (up_ready),
        .up_rvalid     (up_rvalid),
        .up_rdata      (up_rdata),
        .dec_alias     (dec_alias),
        .dec_word_addr (dec_word_addr),
        .dec_bit_idx   (dec_bit_idx),
        .bit_val       (bit_val),
        .merged_in     (merged),
        .bidx_o        (bidx_q),
        .nbit_o        (nbit_q),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_addr       (dn_addr),
        .dn_we         (dn_we),
        .dn_wdata      (dn_wdata),
        .dn_lock       (dn_lock),
        .dn_rvalid     (dn_rvalid),
        .dn_rdata      (dn_rdata)
    );

endmodule

// File: tb/sim_bitalias_bridge.sv
module sim_bitalias_bridge;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_valid, up_we;
    logic [31:0] up_addr, up_wdata;
    logic        up_ready, up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_valid, dn_we, dn_lock;
    logic        dn_ready, dn_rvalid;
    logic [31:0] dn_addr, dn_wdata, dn_rdata;

    always #5 clk = ~clk;

    bitalias_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .up_we(up_we), .up_wdata(up_wdata), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_we(dn_we),
        .dn_wdata(dn_wdata), .dn_lock(dn_lock), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] mem     [bit [31:0]];
    logic [31:0] ref_mem [bit [31:0]];

    int          hs_n, rv_n;
    logic [31:0] hs_addr [4];
    logic [31:0] hs_wd   [4];
    bit          hs_we   [4];
    bit          hs_lock [4];
    bit          busy = 0;
    bit          awr_active = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5a5a_3c3c;
    endfunction

    function automatic logic [31:0] mget(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : seed(a);
    endfunction

    function automatic logic [31:0] rget(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : seed(a);
    endfunction

    // independent address model (R3, R10)
    task automatic bdec(input logic [31:0] a, output bit al, output logic [31:0] w, output int p);
        logic [31:0] off, base, k;
        al = 0; w = a; p = 0; off = 0; base = 0;
        if (a >= 32'h2200_0000 && a < 32'h2400_0000) begin
            al = 1; off = a - 32'h2200_0000; base = 32'h2000_0000;
        end else if (a >= 32'h4200_0000 && a < 32'h4400_0000) begin
            al = 1; off = a - 32'h4200_0000; base = 32'h4000_0000;
        end
        if (al) begin
            k = off / 32;
            w = base + (k & ~32'd3);
            p = int'(k % 4) * 8 + int'((off / 4) % 8);
        end
    endtask

    // downstream memory responder
    int rc = 0;
    initial begin
        bit          pend = 0;
        int          pcnt = 0;
        logic [31:0] pdata = 0;
        dn_ready  = 0;
        dn_rvalid = 0;
        dn_rdata  = 0;
        forever begin
            @(negedge clk);
            rc++;
            dn_rvalid = 0;
            if (!rst_n) begin
                dn_ready = 0;
                pend = 0;
            end else begin
                if (pend) begin
                    if (pcnt == 0) begin
                        dn_rvalid = 1; dn_rdata = pdata; pend = 0;
                    end else pcnt--;
                end
                dn_ready = (rc % 4) != 2;
                if (dn_valid && dn_ready) begin
                    if (hs_n < 4) begin
                        hs_addr[hs_n] = dn_addr; hs_wd[hs_n] = dn_wdata;
                        hs_we[hs_n] = dn_we;     hs_lock[hs_n] = dn_lock;
                    end
                    hs_n++;
                    if (dn_we) begin
                        mem[dn_addr] = dn_wdata; pdata = 32'hBAD0_0000;
                    end else pdata = mget(dn_addr);
                    pend = 1;
                    pcnt = rc % 2;
                end
            end
        end
    end

    // per-clock comparison against the model's busy/lock expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (up_rvalid) rv_n++;
                if (busy && !up_rvalid) chk(!up_ready, "R7", {31'b0, up_ready}, 32'd0);
                if (!awr_active) chk(!dn_lock, "R6", {31'b0, dn_lock}, 32'd0);
            end
        end
    end

    task automatic do_req(input logic [31:0] a, input logic [31:0] wd, input bit we, input string tag);
        bit al; logic [31:0] w, exp_rd, old, nw, got; int p, t;
        bdec(a, al, w, p);
        old = rget(w);
        nw  = old;
        if (!al) begin
            if (we) begin ref_mem[a] = wd; exp_rd = 0; end
            else exp_rd = old;
        end else if (!we) begin
            exp_rd = {31'b0, old[p]};
        end else begin
            nw[p] = wd[0]; ref_mem[w] = nw; exp_rd = 0;
        end
        @(negedge clk);
        up_valid = 1; up_addr = a; up_wdata = wd; up_we = we;
        hs_n = 0; rv_n = 0; awr_active = al && we;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 0; busy = 1;
        t = 0;
        while (!up_rvalid && t < 60) begin @(negedge clk); t++; end
        got = up_rdata;
        busy = 0;
        @(negedge clk);
        #2;
        awr_active = 0;
        chk(got == exp_rd, tag, got, exp_rd);
        chk(rv_n == 1, "R8", rv_n, 1);
        if (al && we) begin
            chk(hs_n == 2, "R6", hs_n, 2);
            if (hs_n == 2) begin
                chk(hs_addr[0] == w && hs_addr[1] == w, "R3", hs_addr[1], w);
                chk(!hs_we[0] && hs_we[1] && hs_lock[0] && hs_lock[1], "R6",
                    {28'b0, hs_we[0], hs_we[1], hs_lock[0], hs_lock[1]}, 32'h7);
                chk(hs_wd[1] == nw, "R5", hs_wd[1], nw);
            end
        end else begin
            chk(hs_n == 1, "R7", hs_n, 1);
            if (hs_n == 1) begin
                chk(hs_addr[0] == w, al ? "R3" : "R1", hs_addr[0], w);
                chk(hs_we[0] == we && !hs_lock[0], "R6", {30'b0, hs_we[0], hs_lock[0]}, {30'b0, we, 1'b0});
                if (we) chk(hs_wd[0] == wd, "R2", hs_wd[0], wd);
            end
        end
        if (we) chk(mget(w) == rget(w), al ? "R5" : "R2", mget(w), rget(w));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; up_valid = 0; up_we = 0; up_addr = 0; up_wdata = 0;
        hs_n = 0; rv_n = 0;
        repeat (3) @(negedge clk);
        chk(up_ready == 1, "R9", {31'b0, up_ready}, 32'd1);
        chk(dn_valid == 0, "R9", {31'b0, dn_valid}, 32'd0);
        chk(dn_lock == 0, "R9", {31'b0, dn_lock}, 32'd0);
        chk(up_rvalid == 0, "R9", {31'b0, up_rvalid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(up_ready == 1 && !dn_valid && !up_rvalid, "R9", {29'b0, up_ready, dn_valid, up_rvalid}, 32'h4);

        do_req(32'h1000_0040, 32'h0,         0, "R1");
        do_req(32'h3000_0008, 32'hDEAD_BEEF, 1, "R2");
        do_req(32'h3000_0008, 32'h0,         0, "R1");
        do_req(32'h4000_0004, 32'h1234_5678, 1, "R2");
        do_req(32'h4000_0004, 32'h0,         0, "R1");
        do_req(32'h2000_0000, 32'h0000_0081, 1, "R2");
        do_req(32'h2200_0000, 32'h0,         0, "R10");
        do_req(32'h2200_0004, 32'h0,         0, "R4");
        do_req(32'h2200_001C, 32'h0,         0, "R4");
        do_req(32'h2200_0004, 32'hFFFF_FFFF, 1, "R5");
        do_req(32'h2200_0000, 32'hFFFF_FFFE, 1, "R5");
        do_req(32'h2000_0000, 32'h0,         0, "R5");
        do_req(32'h2200_0060, 32'h0000_0001, 1, "R3");
        do_req(32'h2200_0080, 32'h0000_0001, 1, "R3");
        do_req(32'h2000_0004, 32'h0,         0, "R3");
        do_req(32'h23FF_FFFC, 32'h0000_0001, 1, "R10");
        do_req(32'h23FF_FFFC, 32'h0,         0, "R10");
        do_req(32'h200F_FFFC, 32'h0,         0, "R10");
        do_req(32'h4000_0000, 32'h0000_0010, 1, "R2");
        do_req(32'h4200_0000, 32'h0,         0, "R10");
        do_req(32'h4200_0000, 32'h0000_0001, 1, "R10");
        do_req(32'h4200_0010, 32'h0000_0002, 1, "R5");
        do_req(32'h4000_0000, 32'h0,         0, "R5");
        do_req(32'h43FF_FFFC, 32'h0,         0, "R10");
        do_req(32'h43FF_FFFC, 32'h7FFF_FFFE, 1, "R10");
        do_req(32'h400F_FFFC, 32'h0,         0, "R10");
        do_req(32'h2400_0000, 32'h0000_0055, 1, "R10");
        do_req(32'h41FF_FFFC, 32'h0,         0, "R10");
        do_req(32'h21FF_FFFC, 32'h0,         0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule